// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Rollover-Aligned Bit Timing

This block is the sending side of a small microcontroller-style asynchronous serial port. Software loads one byte through a write strobe. The block then sends a ten-bit frame on its serial output and raises a completion flag. That flag stays up until software clears it.

Bit timing comes from an external timer overflow pulse. A select input divides the overflow by one or by two to form an oversampling tick at sixteen times the bit rate. A free-running modulo-16 counter divides that tick down. The counter's rollovers, and not the write, mark every bit boundary. The first bit therefore starts 1 to 16 ticks after the write. One bit then follows at each later rollover, and the flag rises together with the stop bit.

Top module: `sertx_top`

## Requirements
- R1: After reset the serial output is 1 and the completion flag is 0.
- R2: A frame is ten bits in this order: a start bit of 0, the eight data bits from bit 0 up to bit 7, and a stop bit of 1.
- R3: The tick counter starts at 0 at reset and advances on every tick. It rolls over on each tick that finds it at 15. The start bit is driven at the first rollover after the write is accepted, so it appears 1 to 16 ticks after the write.
- R4: Each bit after the start bit is driven at the next rollover. The output changes only in the cycle after a rollover, so every bit lasts 16 ticks.
- R5: The flag is set in the same cycle that the stop bit is driven, which is the tenth rollover after the write. The frame is finished at that point.
- R6: The flag holds its value until the clear input is pulsed, and the clear takes effect on the next cycle. If a clear arrives in the cycle the flag is being set, the set wins.
- R7: A write that arrives while a frame is in progress, up to and including the cycle of its tenth rollover, is ignored. The frame in progress keeps its data.
- R8: With the select input at 0 every overflow pulse is a tick, which gives 1/16 of the overflow rate. With select at 1, only every second overflow since reset is a tick, which gives 1/32. The even or odd phase of the overflows is kept even when the select changes.
- R9: The output is 1 whenever no frame is being sent. A write accepted in the cycle after the flag rises starts a new frame, whose start bit comes one full bit time after the stop bit.
- R10: A rollover in the same cycle as the accepted write does not count. In that case the start bit appears 16 ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovf_i | input | 1 | Timer overflow pulse, one cycle wide |
| div32_i | input | 1 | 1 selects bit rate = overflow/32, 0 selects overflow/16 |
| wr_i | input | 1 | Write strobe for the transmit byte |
| wr_data_i | input | 8 | Byte to send |
| ti_clr_i | input | 1 | Clears the completion flag |
| txd_o | output | 1 | Serial output, idles high |
| ti_o | output | 1 | Completion flag |

## Verification
Frames are sent with byte values 0x00, 0xFF, 0xA5 and 0x5A. Together these show up a wrong bit order, a stuck data line and a bad start or stop level. The same transfers run at both divisor settings and with overflows on every cycle or every other cycle, which separates tick counting from clock counting. Writes are placed at different counter phases, including the exact rollover cycle, to confirm the 1-to-16-tick start latency. Writes in the middle of a frame, a clear that collides with a set, and a back-to-back write check that frames stay intact and the flag is handled correctly.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int NSENT_W    = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic               busy;
        logic [NSENT_W-1:0] nsent;
        logic [DATA_W:0]    shreg;
        logic               txd;
        logic               ti;
    } frame_st_t;
endpackage

// File: rtl/sertx_prescale.sv
module sertx_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic div32_i,
    output logic tick_o
);
    logic half_d, half_q;

    always_comb begin
        half_d = half_q;
        if (ovf_i) begin
            half_d = ~half_q;
        end
        tick_o = ovf_i && (!div32_i || half_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= half_d;
        end
    end
endmodule

// File: rtl/sertx_div.sv
module sertx_div #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic roll_o
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        roll_o = tick_i && (cnt_q == LAST);
        if (tick_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              roll_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ti_clr_i,
    output logic              txd_o,
    output logic              ti_o,
    output logic              busy_o
);
    localparam logic [NSENT_W-1:0] LAST_BIT = NSENT_W'(FRAME_BITS - 1);

    frame_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ti_clr_i) begin
            st_d.ti = 1'b0;
        end
        if (roll_i && st_q.busy) begin
            if (st_q.nsent == '0) begin
                st_d.txd = 1'b0;
            end else begin
                st_d.txd   = st_q.shreg[0];
                st_d.shreg = {1'b1, st_q.shreg[DATA_W:1]};
            end
            st_d.nsent = st_q.nsent + 1'b1;
            if (st_q.nsent == LAST_BIT) begin
                st_d.busy = 1'b0;
                st_d.ti   = 1'b1;
            end
        end
        if (wr_i && !st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.nsent = '0;
            st_d.shreg = {1'b1, wr_data_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, nsent: '0, shreg: '1, txd: 1'b1, ti: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign txd_o  = st_q.txd;
    assign ti_o   = st_q.ti;
    assign busy_o = st_q.busy;
endmodule

// File: rtl/sertx_top.sv
module sertx_top (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_i,
    input  logic       div32_i,
    input  logic       wr_i,
    input  logic [7:0] wr_data_i,
    input  logic       ti_clr_i,
    output logic       txd_o,
    output logic       ti_o
);
    logic tick_w;
    logic roll_w;
    logic busy_w;

    sertx_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf_i  (ovf_i),
        .div32_i(div32_i),
        .tick_o (tick_w)
    );

    sertx_div #(.OS_RATE(16)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick_w),
        .roll_o(roll_w)
    );

    sertx_frame u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .roll_i   (roll_w),
        .wr_i     (wr_i),
        .wr_data_i(wr_data_i),
        .ti_clr_i (ti_clr_i),
        .txd_o    (txd_o),
        .ti_o     (ti_o),
        .busy_o   (busy_w)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic ovf,
    input logic ti_clr,
    input logic tick,
    input logic roll,
    input logic busy,
    input logic txd,
    input logic ti
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd) else $error("idle line low"); // R9

    AST_TXD_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        !roll |=> $stable(txd)) else $error("txd moved without rollover"); // R4

    AST_TI_WITH_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ti) |-> $past(roll)) else $error("flag rose off a rollover"); // R5

    AST_TI_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ti && txd) else $error("frame ended without flag"); // R5

    AST_TI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ti && !ti_clr |=> ti) else $error("flag dropped without clear"); // R6

    AST_TICK_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ovf) else $error("tick without overflow"); // R8
endmodule

bind sertx_top sertx_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ovf   (ovf_i),
    .ti_clr(ti_clr_i),
    .tick  (tick_w),
    .roll  (roll_w),
    .busy  (busy_w),
    .txd   (txd_o),
    .ti    (ti_o)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovf_i = 1'b0;
    logic       div32_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       ti_clr_i = 1'b0;
    logic       txd_o, ti_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model, built from the requirements
    logic       m_half = 0, m_busy = 0, m_txd = 1, m_ti = 0, m_rolled = 0;
    logic [3:0] m_cnt = 0;
    int         m_n = 0;
    logic [9:0] m_frame = '1;

    always #4 clk = ~clk;

    sertx_top u_dut (
        .clk(clk), .rst_n(rst_n), .ovf_i(ovf_i), .div32_i(div32_i),
        .wr_i(wr_i), .wr_data_i(wr_data_i), .ti_clr_i(ti_clr_i),
        .txd_o(txd_o), .ti_o(ti_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, sample at next negedge, advance model
    task automatic step(input logic ov, input logic w, input logic [7:0] dat,
                        input logic clr);
        logic tk, rl, set, b0;
        ovf_i = ov; wr_i = w; wr_data_i = dat; ti_clr_i = clr;
        @(negedge clk);
        ovf_i = 0; wr_i = 0; ti_clr_i = 0;
        b0  = m_busy;
        set = 0;
        tk  = ov && (!div32_i || m_half);
        if (ov) m_half = ~m_half;
        rl  = tk && (m_cnt == 4'd15);
        if (tk) m_cnt = m_cnt + 4'd1;
        m_rolled = rl && b0;
        if (rl && b0) begin
            m_txd = m_frame[m_n];
            m_n++;
            if (m_n == 10) begin m_busy = 0; set = 1; end
        end
        if (clr) m_ti = 0;
        if (set) m_ti = 1;
        if (w && !b0) begin
            m_busy = 1; m_n = 0; m_frame = {1'b1, dat, 1'b0};
        end
        check("R4 txd per cycle", int'(txd_o), int'(m_txd));
        check("R6 flag per cycle", int'(ti_o), int'(m_ti));
    endtask

    // send one byte; ovf every 'gap' cycles; optionally a second write mid-frame
    task automatic send(input logic [7:0] dat, input int gap, input bit intrude,
                        input string tag);
        logic [9:0] cap = '0;
        int k = 0, pulses = 0, last = 0, per;
        per = div32_i ? 32 : 16;
        step(0, 1, dat, 0);
        while (k < 10) begin
            for (int g = 1; g < gap; g++) step(0, 0, 8'h00, 0);
            step(1, (intrude && k == 4), ~dat, 0);
            pulses++;
            if (m_rolled) begin
                cap[k] = txd_o;
                if (k == 0) begin
                    checks++;
                    if (pulses < 1 || pulses > per) begin
                        errors++;
                        $display("FAIL R3 %s: start latency actual=%0d expected=1..%0d",
                                 tag, pulses, per);
                    end
                end else begin
                    check({"R4 bit width ", tag}, pulses - last, per);
                end
                last = pulses;
                k++;
            end
            if (pulses > 400) break;
        end
        check({"R2 frame ", tag}, int'(cap), int'({1'b1, dat, 1'b0}));
        check({"R5 flag at stop ", tag}, int'(ti_o), 1);
    endtask

    task automatic t_reset;
        check("R1 txd reset", int'(txd_o), 1);
        check("R1 flag reset", int'(ti_o), 0);
    endtask

    task automatic t_clear;
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        check("R6 flag held", int'(ti_o), 1);
        step(0, 0, 8'h00, 1);
        check("R6 flag cleared", int'(ti_o), 0);
        check("R9 idle high", int'(txd_o), 1);
    endtask

    task automatic t_clear_collide;
        step(0, 1, 8'h3C, 0);
        while (!(m_busy && m_n == 9 && m_cnt == 4'd15)) step(1, 0, 8'h00, 0);
        step(1, 0, 8'h00, 1);
        check("R6 set wins over clear", int'(ti_o), 1);
        step(0, 0, 8'h00, 1);
    endtask

    task automatic t_write_on_roll;
        int pulses = 0;
        while (m_cnt != 4'd15) step(1, 0, 8'h00, 0);
        step(1, 1, 8'h81, 0);
        while (!m_rolled && pulses < 40) begin step(1, 0, 8'h00, 0); pulses++; end
        check("R10 start after 16 ticks", pulses, 16);
        check("R10 start bit low", int'(txd_o), 0);
        while (m_busy) step(1, 0, 8'h00, 0);
        step(0, 0, 8'h00, 1);
    endtask

    task automatic t_back_to_back;
        int pulses = 0;
        step(0, 1, 8'hC3, 0);
        while (m_busy) step(1, 0, 8'h00, 0);
        step(0, 1, 8'h0F, 0);
        check("R9 line high after stop", int'(txd_o), 1);
        while (!m_rolled && pulses < 40) begin step(1, 0, 8'h00, 0); pulses++; end
        check("R9 next start one bit later", pulses, 16);
        while (m_busy) step(1, 0, 8'h00, 0);
        step(0, 0, 8'h00, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        send(8'hA5, 1, 0, "A5 div16");
        t_clear();
        step(1, 0, 8'h00, 0); step(1, 0, 8'h00, 0); step(1, 0, 8'h00, 0);
        send(8'h5A, 2, 0, "5A gap2");
        t_clear();
        send(8'h00, 1, 1, "R7 intrude 00");
        t_clear();
        send(8'hFF, 1, 1, "R7 intrude FF");
        t_clear();
        div32_i = 1;
        step(1, 0, 8'h00, 0);
        send(8'h96, 1, 0, "R8 div32");
        t_clear();
        div32_i = 0;
        t_clear_collide();
        t_write_on_roll();
        t_back_to_back();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule